// File: doc/BRIEF.md
# Halftone and Logic Operation Unit

This block forms the data word that a raster copy engine writes back for one 16-bit destination location. A pattern stage chooses between a constant, a halftone row, the aligned source word, or the source masked by a halftone row. A logic stage then combines that pattern-stage word with the destination word using any of the sixteen two-input Boolean functions. A final merge keeps the destination bits that lie outside an edge mask. Address generation and bus sequencing sit outside this block. They supply the aligned source word and the destination read data, and they use the block's destination-needed flag to decide whether a destination read must be issued for the word.

The block holds a 16-row halftone pattern store. Software writes it one row at a time, and it can be read back through a separate read address. The row used by the datapath comes from an internal 4-bit line counter, or, in smudge mode, from the low nibble of the source word. The line counter is loaded by the engine at the start of a copy and stepped once at each line end, up or down according to the sign of the destination line stride.

All datapath outputs are combinational functions of the current inputs and the stored configuration. Configuration writes and line-counter updates take effect at the next rising clock edge.

Top module: `ht_rop_unit`

## Requirements
- R1: After a synchronous active-low reset, every pattern row reads 0, the pattern-mode and logic-op registers read 0, and the line counter reads 0.
- R2: A pattern write with row address A (0 to 15) stores the 16-bit data in row A. The read port then returns, for any read address, the last value written to that row.
- R3: An 8-bit write to the pattern-mode register keeps only bits [1:0]. An 8-bit write to the logic-op register keeps only bits [3:0]. Both registers are visible on their read-back outputs.
- R4: The pattern-stage word H depends on the mode. Mode 0 gives all ones. Mode 1 gives the selected halftone row. Mode 2 gives the source word. Mode 3 gives the source word AND the selected halftone row.
- R5: With smudge low, the halftone row is selected by the line counter. With smudge high, it is selected by bits [3:0] of the source word.
- R6: For each bit, the logic result equals bit {~H,~D} of the 4-bit op code, with ~H as the upper index bit. Some examples: 0 gives 0, 1 gives H AND D, 3 gives H, 5 gives D, 6 gives H XOR D, 7 gives H OR D, 0xA gives NOT D, and 0xF gives all ones.
- R7: The output word is (result AND mask) OR (destination AND NOT mask). With the mask all ones, it is the logic result unchanged.
- R8: The destination-needed flag is high in either of two cases: the op code makes the result depend on D, that is op[0]!=op[1] or op[2]!=op[3]; or a merge is required, that is the mask is not all ones or the no-final-read flag is high. Otherwise the flag is low.
- R9: A line-load pulse sets the line counter to the given 4-bit value, and it takes priority over a step. A line-step pulse adds 1 modulo 16 when the stride-negative input is low, and subtracts 1 modulo 16 when it is high. With no pulse, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_we | input | 1 | Pattern row write strobe |
| pat_waddr | input | 4 | Pattern row write address |
| pat_wdata | input | 16 | Pattern row write data |
| pat_raddr | input | 4 | Pattern row read-back address |
| pat_rdata | output | 16 | Pattern row read-back data |
| hmode_we | input | 1 | Pattern-mode register write strobe |
| hmode_wdata | input | 8 | Pattern-mode write byte |
| hmode_q | output | 2 | Pattern-mode register value |
| lop_we | input | 1 | Logic-op register write strobe |
| lop_wdata | input | 8 | Logic-op write byte |
| lop_q | output | 4 | Logic-op register value |
| smudge | input | 1 | Select the halftone row from the source nibble |
| line_load | input | 1 | Load the line counter |
| line_init | input | 4 | Line counter load value |
| line_step | input | 1 | Line-end step pulse |
| dy_neg | input | 1 | Destination line stride is negative |
| line_q | output | 4 | Current line counter |
| src_word | input | 16 | Aligned source word |
| dst_word | input | 16 | Destination read word |
| edge_mask | input | 16 | Edge mask for this word |
| no_final_read | input | 1 | No-final-read flag for this word |
| wr_word | output | 16 | Word to write |
| dst_needed | output | 1 | Destination read required |

## Verification
The checker assumes that the destination word input is stable while the engine samples the output. When the mask is all ones, the flag is low and the op code ignores D, it also assumes that no destination read is pending. It further assumes that load and step pulses are single-cycle and that write strobes are never X after reset. The bench changes every input only on falling edges, drives only one configuration strobe at a time, and holds the datapath inputs constant for a full cycle while it samples. This keeps the stimulus inside these assumptions while it sweeps all mode, op and smudge combinations over every pattern row.

// File: rtl/ht_rop_pkg.sv
// Shared widths and pattern-mode encoding for the halftone/logic-op unit.
package ht_rop_pkg;
    localparam int WORD_W = 16;
    localparam int ROW_W  = 4;

    typedef enum logic [1:0] {
        HM_ONES    = 2'd0,
        HM_PATTERN = 2'd1,
        HM_SOURCE  = 2'd2,
        HM_SRC_AND = 2'd3
    } hmode_e;
endpackage

// File: rtl/ht_pattern_ram.sv
// Halftone pattern store: ROWS registers of DW bits, one synchronous write
// port and two combinational read ports (software read-back, datapath).
// Assumes addresses are in range; ROWS is a power of two.
module ht_pattern_ram #(
    parameter int DW   = 16,
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] rows [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        // Each row captures write data when addressed; clears on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rows[g] <= '0;
            else if (we && waddr == AW'(g))
                rows[g] <= wdata;
        end
    end

    // Read ports are plain multiplexers.
    assign rdata_a = rows[raddr_a];
    assign rdata_b = rows[raddr_b];
endmodule

// File: rtl/ht_line_counter.sv
// Modulo-2^W line counter: load has priority, step moves up or down by one.
// Assumes load and step are single-cycle pulses from the engine.
module ht_line_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] count
);
    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= init;
        else if (step)
            count <= down ? count - W'(1) : count + W'(1);
    end
endmodule

// File: rtl/ht_rop_core.sv
// Combinational datapath: pattern stage, 16-function logic stage and
// edge-mask merge, plus the destination-needed decision.
// Assumes hrow is already the row selected for this word.
module ht_rop_core
    import ht_rop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [1:0]    hmode,
    input  logic [3:0]    lop,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] hrow,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] mask,
    input  logic          final_flag,
    output logic [DW-1:0] result,
    output logic          need_dst
);
    logic [DW-1:0] h_word;
    logic [DW-1:0] op_word;
    logic          uses_d;
    logic          merge;

    // Pattern stage selection.
    always_comb begin
        unique case (hmode_e'(hmode))
            HM_ONES:    h_word = '1;
            HM_PATTERN: h_word = hrow;
            HM_SOURCE:  h_word = src;
            default:    h_word = src & hrow;
        endcase
    end

    // Per-bit truth-table lookup with index {~H,~D}.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign op_word[b] = lop[{~h_word[b], ~dst[b]}];
    end

    // Destination dependence and merge decision.
    always_comb begin
        uses_d   = (lop[0] ^ lop[1]) | (lop[2] ^ lop[3]);
        merge    = final_flag | (mask != '1);
        need_dst = uses_d | merge;
        result   = (op_word & mask) | (dst & ~mask);
    end
endmodule

// File: rtl/ht_rop_unit.sv
// Top of the halftone/logic-op unit: configuration registers, pattern
// store, line counter and datapath. Assumes the engine drives dst_word
// with valid read data whenever dst_needed is high.
module ht_rop_unit
    import ht_rop_pkg::*;
#(
    parameter int DW   = WORD_W,
    parameter int ROWS = 1 << ROW_W,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pat_we,
    input  logic [AW-1:0] pat_waddr,
    input  logic [DW-1:0] pat_wdata,
    input  logic [AW-1:0] pat_raddr,
    output logic [DW-1:0] pat_rdata,
    input  logic          hmode_we,
    input  logic [7:0]    hmode_wdata,
    output logic [1:0]    hmode_q,
    input  logic          lop_we,
    input  logic [7:0]    lop_wdata,
    output logic [3:0]    lop_q,
    input  logic          smudge,
    input  logic          line_load,
    input  logic [AW-1:0] line_init,
    input  logic          line_step,
    input  logic          dy_neg,
    output logic [AW-1:0] line_q,
    input  logic [DW-1:0] src_word,
    input  logic [DW-1:0] dst_word,
    input  logic [DW-1:0] edge_mask,
    input  logic          no_final_read,
    output logic [DW-1:0] wr_word,
    output logic          dst_needed
);
    logic [AW-1:0] row_sel;
    logic [DW-1:0] row_word;

    // Mode and op registers keep only their meaningful low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hmode_q <= '0;
            lop_q   <= '0;
        end else begin
            if (hmode_we) hmode_q <= hmode_wdata[1:0];
            if (lop_we)   lop_q   <= lop_wdata[3:0];
        end
    end

    // Row selection: line counter, or source nibble in smudge mode.
    assign row_sel = smudge ? src_word[AW-1:0] : line_q;

    ht_pattern_ram #(.DW(DW), .ROWS(ROWS)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pat_we),
        .waddr   (pat_waddr),
        .wdata   (pat_wdata),
        .raddr_a (pat_raddr),
        .rdata_a (pat_rdata),
        .raddr_b (row_sel),
        .rdata_b (row_word)
    );

    ht_line_counter #(.W(AW)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (line_load),
        .init  (line_init),
        .step  (line_step),
        .down  (dy_neg),
        .count (line_q)
    );

    ht_rop_core #(.DW(DW)) u_core (
        .hmode      (hmode_q),
        .lop        (lop_q),
        .src        (src_word),
        .hrow       (row_word),
        .dst        (dst_word),
        .mask       (edge_mask),
        .final_flag (no_final_read),
        .result     (wr_word),
        .need_dst   (dst_needed)
    );
endmodule

// File: rtl/ht_rop_unit_chk.sv
// Property checker for ht_rop_unit, attached by bind below.
module ht_rop_unit_chk #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pat_we,
    input logic [AW-1:0] pat_waddr,
    input logic [DW-1:0] pat_wdata,
    input logic [AW-1:0] pat_raddr,
    input logic [DW-1:0] pat_rdata,
    input logic [3:0]    lop_q,
    input logic          line_load,
    input logic          line_step,
    input logic          dy_neg,
    input logic [AW-1:0] line_q,
    input logic [DW-1:0] dst_word,
    input logic [DW-1:0] edge_mask,
    input logic          no_final_read,
    input logic [DW-1:0] wr_word,
    input logic          dst_needed
);
    // R2
    pat_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_we |=> (pat_raddr != $past(pat_waddr) || pat_rdata == $past(pat_wdata)));
    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_word & ~edge_mask) == (dst_word & ~edge_mask)));
    // R8
    no_dread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lop_q == 4'h0 && edge_mask == '1 && !no_final_read) |-> !dst_needed);
    // R8
    merge_dread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mask != '1 || no_final_read) |-> dst_needed);
    // R9
    line_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && !line_load && !dy_neg) |=> line_q == $past(line_q) + AW'(1));
    // R9
    line_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && !line_load && dy_neg) |=> line_q == $past(line_q) - AW'(1));
    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_step && !line_load) |=> $stable(line_q));
endmodule

bind ht_rop_unit ht_rop_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pat_we        (pat_we),
    .pat_waddr     (pat_waddr),
    .pat_wdata     (pat_wdata),
    .pat_raddr     (pat_raddr),
    .pat_rdata     (pat_rdata),
    .lop_q         (lop_q),
    .line_load     (line_load),
    .line_step     (line_step),
    .dy_neg        (dy_neg),
    .line_q        (line_q),
    .dst_word      (dst_word),
    .edge_mask     (edge_mask),
    .no_final_read (no_final_read),
    .wr_word       (wr_word),
    .dst_needed    (dst_needed)
);

// File: tb/ht_rop_unit_bench.sv
`timescale 1ns/1ps
module ht_rop_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 1'b0;
    logic [3:0]  pat_waddr = '0;
    logic [15:0] pat_wdata = '0;
    logic [3:0]  pat_raddr = '0;
    logic [15:0] pat_rdata;
    logic        hmode_we = 1'b0;
    logic [7:0]  hmode_wdata = '0;
    logic [1:0]  hmode_q;
    logic        lop_we = 1'b0;
    logic [7:0]  lop_wdata = '0;
    logic [3:0]  lop_q;
    logic        smudge = 1'b0;
    logic        line_load = 1'b0;
    logic [3:0]  line_init = '0;
    logic        line_step = 1'b0;
    logic        dy_neg = 1'b0;
    logic [3:0]  line_q;
    logic [15:0] src_word = '0;
    logic [15:0] dst_word = '0;
    logic [15:0] edge_mask = 16'hFFFF;
    logic        no_final_read = 1'b0;
    logic [15:0] wr_word;
    logic        dst_needed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ht_rop_unit u_ht_rop_unit (.*);

    function automatic logic [15:0] row_val(input int r);
        return 16'(((r * 16'h1357) ^ 16'hA5C3) + r * 7);
    endfunction

    function automatic logic [15:0] rop(input logic [3:0] op, input logic [15:0] h,
                                        input logic [15:0] d);
        logic [15:0] o;
        for (int b = 0; b < 16; b++) o[b] = op[{~h[b], ~d[b]}];
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_pat(input int r, input logic [15:0] v);
        pat_we = 1'b1; pat_waddr = 4'(r); pat_wdata = v;
        tick();
        pat_we = 1'b0;
    endtask

    task automatic wr_modes(input logic [7:0] hm, input logic [7:0] op);
        hmode_we = 1'b1; hmode_wdata = hm;
        tick();
        hmode_we = 1'b0; lop_we = 1'b1; lop_wdata = op;
        tick();
        lop_we = 1'b0;
    endtask

    initial begin
        logic [15:0] hrow, hw, exp_w;
        logic [3:0]  ln;
        logic        need;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 hmode", 32'(hmode_q), 32'h0);
        chk("R1 lop", 32'(lop_q), 32'h0);
        chk("R1 line", 32'(line_q), 32'h0);
        for (int r = 0; r < 16; r++) begin
            pat_raddr = 4'(r); #0.1;
            chk("R1 pattern row", 32'(pat_rdata), 32'h0);
        end
        tick();
        // R2 fill and read back every row
        for (int r = 0; r < 16; r++) wr_pat(r, 16'hFFFF);
        for (int r = 0; r < 16; r++) wr_pat(r, row_val(r));
        for (int r = 0; r < 16; r++) begin
            pat_raddr = 4'(15 - r); #0.1;
            chk("R2 pattern readback", 32'(pat_rdata), 32'(row_val(15 - r)));
        end
        // R3 masking of register writes
        wr_modes(8'hFE, 8'hA9);
        #1;
        chk("R3 hmode low bits", 32'(hmode_q), 32'h2);
        chk("R3 lop low bits", 32'(lop_q), 32'h9);
        // R9 line counter wrap and priority
        tick();
        line_load = 1'b1; line_init = 4'hF; line_step = 1'b1; dy_neg = 1'b1;
        tick();
        line_load = 1'b0; line_step = 1'b0; #1;
        chk("R9 load priority", 32'(line_q), 32'hF);
        line_step = 1'b1; dy_neg = 1'b0;
        tick(); line_step = 1'b0; #1;
        chk("R9 up wrap", 32'(line_q), 32'h0);
        line_step = 1'b1; dy_neg = 1'b1;
        tick(); line_step = 1'b0; #1;
        chk("R9 down wrap", 32'(line_q), 32'hF);
        tick(); #1;
        chk("R9 hold", 32'(line_q), 32'hF);
        // R4 R5 R6 R7 R8 sweep
        for (int hm = 0; hm < 4; hm++) begin
            for (int op = 0; op < 16; op++) begin
                wr_modes(8'(hm | 8'h3C), 8'(op | 8'h50));
                for (int sm = 0; sm < 2; sm++) begin
                    for (int v = 0; v < 6; v++) begin
                        smudge = sm[0];
                        src_word = 16'(v * 16'h3B5D + op * 3 + hm);
                        dst_word = 16'(v * 16'h71C9 ^ 16'h0FF0);
                        edge_mask = (v % 3 == 0) ? 16'hFFFF : 16'(16'hFFFF >> v);
                        no_final_read = (v == 3);
                        line_step = 1'b1; dy_neg = v[0];
                        tick();
                        line_step = 1'b0;
                        #1;
                        ln = line_q;
                        hrow = row_val(sm ? int'(src_word[3:0]) : int'(ln));
                        case (hm)
                            0: hw = 16'hFFFF;
                            1: hw = hrow;
                            2: hw = src_word;
                            default: hw = src_word & hrow;
                        endcase
                        exp_w = (rop(4'(op), hw, dst_word) & edge_mask) |
                                (dst_word & ~edge_mask);
                        need = (op[0] ^ op[1]) | (op[2] ^ op[3]) |
                               (edge_mask != 16'hFFFF) | no_final_read;
                        chk("R4/R5/R6/R7 word (R4 R5 R6 R7)", 32'(wr_word), 32'(exp_w));
                        chk("R8 dst needed", 32'(dst_needed), 32'(need));
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule